// File: doc/BRIEF.md
# Dual External Trigger Timestamp Capture

This block watches two asynchronous trigger pins. When the chosen edge appears on either pin, it stores the current 64-bit nanosecond time in a 64-bit register for that channel. It also sends a one-cycle strobe to the event unit. Each pin goes through a two-stage synchronizer and then an edge detector, and all of this runs in the timer clock domain. A control bit per channel sets whether a rising or a falling edge counts. A global enable bit gates all captures. The running time and the interrupt logic live outside this block: the time comes in on a port, and events leave as pulses.

Software reads each capture as two 32-bit words, high word first. Reading the high word copies the matching low half into a per-channel snapshot. The low-word read that follows returns this snapshot, so the two halves always come from the same capture, even if a later trigger has overwritten the register in between. The stored stamp is the time on the cycle the synchronized edge is seen. That is two timer cycles after the pin is first sampled, and the block does not correct for this delay.

Top module: `trig_stamp_capture`

## Requirements
- R1: After reset, all four readable words are zero and `evt_vec` is zero.
- R2: Channel 0 captures on a rising edge when `ctrl_word[8]` is 0 and on a falling edge when it is 1; the other edge is ignored.
- R3: Channel 1 captures on a rising edge when `ctrl_word[9]` is 0 and on a falling edge when it is 1; the other edge is ignored.
- R4: The captured value equals `time_ns` as sampled two clock edges after the edge that first samples the trigger change (the capture edge itself).
- R5: A capture on channel 0 raises `evt_vec[24]`, and a capture on channel 1 raises `evt_vec[25]`, each for exactly one cycle; all other bits stay zero.
- R6: While `ctrl_word[2]` (timer enable) is 0, trigger edges produce neither a capture nor an event.
- R7: A new capture overwrites the stored stamp even if the previous one was never read.
- R8: A read with `rd_en` high returns data on `rd_data` one cycle later. The address map is: 0 = channel 0 high word, 1 = channel 0 low word, 2 = channel 1 high word, 3 = channel 1 low word. `rd_data` holds its value when there is no read.
- R9: A low-word read returns the low half that was copied when the same channel's high word was last read.
- R10: Edges on both channels in the same cycle capture the same time and raise both event bits together.
- R11: Changing a polarity bit while the trigger level is steady causes no capture.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Timer clock |
| rst | input | 1 | Synchronous active-high reset |
| ctrl_word | input | 32 | Control: bit 2 enable, bit 8 channel 0 polarity, bit 9 channel 1 polarity (1 = falling) |
| time_ns | input | 64 | Current time in nanoseconds |
| trig_in | input | 2 | Asynchronous trigger pins, bit 0 = channel 0 |
| rd_en | input | 1 | Read strobe |
| rd_addr | input | 2 | Word select: bit 1 picks the channel, bit 0 picks low (1) or high (0) |
| rd_data | output | 32 | Registered read data |
| evt_vec | output | 32 | Event pulses, bit 24 = channel 0, bit 25 = channel 1 |

## Verification
A capture and a high-word read of the same channel can land on the same clock edge. The bench provokes this by raising the read strobe exactly on the cycle the synchronized edge is acted on. It then expects the high word and the following low word to both come from the older capture, and a fresh read pair to return the new stamp. The bench also fires both channels on one edge. It judges that case by requiring both event bits in the same cycle and identical stamps in the two channels.

// File: rtl/tsc_pkg.sv
package tsc_pkg;
  localparam int N_CH          = 2;
  localparam int CH_W          = (N_CH > 1) ? $clog2(N_CH) : 1;
  localparam int ADDR_W        = CH_W + 1;
  localparam int CTRL_EN_BIT   = 2;
  localparam int CTRL_POL_BASE = 8;
  localparam int EVT_BASE      = 24;

  typedef enum logic {
    EDGE_RISE = 1'b0,
    EDGE_FALL = 1'b1
  } edge_pol_e;
endpackage

// File: rtl/tsc_sync_edge.sv
module tsc_sync_edge #(
  parameter int STAGES = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              din,
  input  tsc_pkg::edge_pol_e pol,
  output logic              edge_o
);
  logic [STAGES-1:0] sync_q;
  logic              prev_q;
  logic              lvl;

  always_ff @(posedge clk) begin
    if (rst) begin
      sync_q <= '0;
      prev_q <= 1'b0;
    end else begin
      sync_q <= {sync_q[STAGES-2:0], din};
      prev_q <= sync_q[STAGES-1];
    end
  end

  assign lvl = sync_q[STAGES-1];

  // Compare raw levels so a polarity switch alone never looks like an edge.
  always_comb begin
    if (pol == tsc_pkg::EDGE_FALL) edge_o = prev_q & ~lvl;
    else                           edge_o = lvl & ~prev_q;
  end
endmodule

// File: rtl/tsc_chan.sv
module tsc_chan #(
  parameter int STAMP_W = 64
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               fire,
  input  logic [STAMP_W-1:0] time_ns,
  output logic [STAMP_W-1:0] stamp_q,
  output logic               evt_q
);
  always_ff @(posedge clk) begin
    if (rst) begin
      stamp_q <= '0;
      evt_q   <= 1'b0;
    end else begin
      evt_q <= fire;
      if (fire) stamp_q <= time_ns;
    end
  end
endmodule

// File: rtl/tsc_rd_port.sv
module tsc_rd_port #(
  parameter int N_CH   = 2,
  parameter int WORD_W = 32,
  parameter int CH_W   = 1,
  parameter int ADDR_W = 2
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic                       rd_en,
  input  logic [ADDR_W-1:0]          rd_addr,
  input  logic [N_CH*2*WORD_W-1:0]   stamps_flat,
  output logic [WORD_W-1:0]          rd_data
);
  localparam int STAMP_W = 2 * WORD_W;

  logic [WORD_W-1:0] shadow_q [N_CH];
  logic [CH_W-1:0]   ch;
  logic              lo_sel;
  logic [WORD_W-1:0] hi_word;
  logic [WORD_W-1:0] lo_word;
  int                base;

  assign ch     = rd_addr[ADDR_W-1:1];
  assign lo_sel = rd_addr[0];

  always_comb begin
    base    = int'(ch) * STAMP_W;
    hi_word = stamps_flat[base + WORD_W +: WORD_W];
    lo_word = stamps_flat[base +: WORD_W];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_data <= '0;
      for (int i = 0; i < N_CH; i++) shadow_q[i] <= '0;
    end else if (rd_en) begin
      if (!lo_sel) begin
        rd_data      <= hi_word;
        shadow_q[ch] <= lo_word;
      end else begin
        rd_data <= shadow_q[ch];
      end
    end
  end
endmodule

// File: rtl/trig_stamp_capture.sv
module trig_stamp_capture #(
  parameter int WORD_W      = 32,
  parameter int SYNC_STAGES = 2
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic [31:0]                ctrl_word,
  input  logic [2*WORD_W-1:0]        time_ns,
  input  logic [tsc_pkg::N_CH-1:0]   trig_in,
  input  logic                       rd_en,
  input  logic [tsc_pkg::ADDR_W-1:0] rd_addr,
  output logic [WORD_W-1:0]          rd_data,
  output logic [31:0]                evt_vec
);
  import tsc_pkg::*;
  localparam int STAMP_W = 2 * WORD_W;

  logic                      timer_en;
  logic [N_CH-1:0]           edge_w;
  logic [N_CH-1:0]           chan_evt;
  logic [STAMP_W-1:0]        stamp_w [N_CH];
  logic [N_CH*STAMP_W-1:0]   stamps_flat;
  logic                      ctrl_unused;

  assign timer_en    = ctrl_word[CTRL_EN_BIT];
  assign ctrl_unused = ^{ctrl_word[31:CTRL_POL_BASE+N_CH],
                         ctrl_word[CTRL_POL_BASE-1:CTRL_EN_BIT+1],
                         ctrl_word[CTRL_EN_BIT-1:0]};

  for (genvar g = 0; g < N_CH; g++) begin : g_ch
    tsc_sync_edge #(.STAGES(SYNC_STAGES)) u_sync (
      .clk    (clk),
      .rst    (rst),
      .din    (trig_in[g]),
      .pol    (edge_pol_e'(ctrl_word[CTRL_POL_BASE+g])),
      .edge_o (edge_w[g])
    );

    tsc_chan #(.STAMP_W(STAMP_W)) u_chan (
      .clk     (clk),
      .rst     (rst),
      .fire    (edge_w[g] & timer_en),
      .time_ns (time_ns),
      .stamp_q (stamp_w[g]),
      .evt_q   (chan_evt[g])
    );

    assign stamps_flat[g*STAMP_W +: STAMP_W] = stamp_w[g];
  end

  always_comb begin
    evt_vec = '0;
    for (int i = 0; i < N_CH; i++) evt_vec[EVT_BASE+i] = chan_evt[i];
  end

  tsc_rd_port #(
    .N_CH   (N_CH),
    .WORD_W (WORD_W),
    .CH_W   (CH_W),
    .ADDR_W (ADDR_W)
  ) u_rd (
    .clk         (clk),
    .rst         (rst),
    .rd_en       (rd_en),
    .rd_addr     (rd_addr),
    .stamps_flat (stamps_flat),
    .rd_data     (rd_data)
  );
endmodule

// File: rtl/tsc_checker.sv
module tsc_checker (
  input logic        clk,
  input logic        rst,
  input logic [31:0] ctrl_word,
  input logic [63:0] time_ns,
  input logic [31:0] evt_vec,
  input logic        rd_en,
  input logic [31:0] rd_data,
  input logic [63:0] stamp_a,
  input logic [63:0] stamp_b
);
  import tsc_pkg::*;

  p_pulse_a_r5: assert property (@(posedge clk) disable iff (rst)
    evt_vec[EVT_BASE] |=> !evt_vec[EVT_BASE]);

  p_pulse_b_r5: assert property (@(posedge clk) disable iff (rst)
    evt_vec[EVT_BASE+1] |=> !evt_vec[EVT_BASE+1]);

  p_gated_off_r6: assert property (@(posedge clk) disable iff (rst)
    !ctrl_word[CTRL_EN_BIT] |=> evt_vec == 32'h0);

  p_value_a_r4: assert property (@(posedge clk) disable iff (rst)
    evt_vec[EVT_BASE] |-> stamp_a == $past(time_ns));

  p_value_b_r4: assert property (@(posedge clk) disable iff (rst)
    evt_vec[EVT_BASE+1] |-> stamp_b == $past(time_ns));

  p_change_a_r7: assert property (@(posedge clk) disable iff (rst)
    !$stable(stamp_a) |-> evt_vec[EVT_BASE]);

  p_change_b_r7: assert property (@(posedge clk) disable iff (rst)
    !$stable(stamp_b) |-> evt_vec[EVT_BASE+1]);

  p_rd_hold_r8: assert property (@(posedge clk) disable iff (rst)
    !rd_en |=> $stable(rd_data));
endmodule

bind trig_stamp_capture tsc_checker u_tsc_checker (
  .clk       (clk),
  .rst       (rst),
  .ctrl_word (ctrl_word),
  .time_ns   (time_ns),
  .evt_vec   (evt_vec),
  .rd_en     (rd_en),
  .rd_data   (rd_data),
  .stamp_a   (stamp_w[0]),
  .stamp_b   (stamp_w[1])
);

// File: tb/trig_stamp_capture_tb_top.sv
module trig_stamp_capture_tb_top;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [31:0] ctrl_word = 32'h0;
  logic [63:0] time_ns = 64'h0000_0007_FFFF_FFF0;
  logic [1:0]  trig_in = 2'b00;
  logic        rd_en = 1'b0;
  logic [1:0]  rd_addr = 2'b00;
  logic [31:0] rd_data;
  logic [31:0] evt_vec;

  int n_chk = 0;
  int n_bad = 0;
  logic [63:0] exp_stamp [2];

  // {channel, polarity, new level, capture expected}
  localparam logic [3:0] VEC [8] = '{
    4'b0011, 4'b0000, 4'b0110, 4'b0101,
    4'b1011, 4'b1000, 4'b1110, 4'b1101
  };

  always #4 clk = ~clk;
  always @(negedge clk) time_ns <= time_ns + 64'd1;

  trig_stamp_capture dut_i (
    .clk       (clk),
    .rst       (rst),
    .ctrl_word (ctrl_word),
    .time_ns   (time_ns),
    .trig_in   (trig_in),
    .rd_en     (rd_en),
    .rd_addr   (rd_addr),
    .rd_data   (rd_data),
    .evt_vec   (evt_vec)
  );

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic rd_word(input logic [1:0] a, output logic [31:0] d);
    @(negedge clk);
    rd_en   = 1'b1;
    rd_addr = a;
    @(negedge clk);
    d     = rd_data;
    rd_en = 1'b0;
  endtask

  task automatic rd_stamp(input logic ch, output logic [63:0] v);
    logic [31:0] hi, lo;
    rd_word({ch, 1'b0}, hi);
    rd_word({ch, 1'b1}, lo);
    v = {hi, lo};
  endtask

  // Drives a new level; returns the time the capture edge will see.
  task automatic drive(input int ch, input logic lvl, output logic [63:0] v);
    @(negedge clk);
    #1;
    v = time_ns + 64'd2;
    trig_in[ch] = lvl;
  endtask

  task automatic settle();
    repeat (4) @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("  test done: total=%0d bad=%0d", n_chk + 1, n_bad);
    $finish;
  end

  initial begin
    logic [63:0] v, v2, got;
    logic [31:0] w;
    logic        seen;
    exp_stamp[0] = '0;
    exp_stamp[1] = '0;

    repeat (5) @(negedge clk);
    rst = 1'b0;
    // R1: reset state
    check("R1 evt", 64'(evt_vec), 64'h0);
    rd_stamp(1'b0, got); check("R1 ch0", got, 64'h0);
    rd_stamp(1'b1, got); check("R1 ch1", got, 64'h0);

    ctrl_word[2] = 1'b1;
    // Table walk: R2 on channel 0, R3 on channel 1
    foreach (VEC[i]) begin
      logic ch, pol, lvl, ex;
      {ch, pol, lvl, ex} = VEC[i];
      ctrl_word[8 + ch] = pol;
      settle();
      drive(int'(ch), lvl, v);
      repeat (3) @(negedge clk);
      check(ch ? "R3 evt" : "R2 evt", 64'(evt_vec), ex ? (64'h1 << (24 + ch)) : 64'h0);
      @(negedge clk);
      if (ex) check("R5 pulse ends", 64'(evt_vec), 64'h0);
      if (ex) exp_stamp[ch] = v;
      rd_stamp(ch, got);
      check(ch ? "R3/R4/R8 stamp" : "R2/R4/R8 stamp", got, exp_stamp[ch]);
    end

    // Directed: rising polarity on both channels, levels low
    ctrl_word[9:8] = 2'b00;
    trig_in = 2'b00;
    settle();
    settle();

    // R11: polarity flip with steady high level gives no capture
    drive(0, 1'b1, v);
    exp_stamp[0] = v;
    settle();
    ctrl_word[8] = 1'b1;
    seen = 1'b0;
    repeat (6) begin
      @(negedge clk);
      seen = seen | evt_vec[24];
    end
    check("R11 no event", 64'(seen), 64'h0);
    rd_stamp(1'b0, got); check("R11 stamp kept", got, exp_stamp[0]);
    ctrl_word[8] = 1'b0;
    drive(0, 1'b0, v);
    settle();

    // R6: disabled timer ignores edges
    ctrl_word[2] = 1'b0;
    drive(0, 1'b1, v);
    repeat (3) @(negedge clk);
    check("R6 no event", 64'(evt_vec), 64'h0);
    rd_stamp(1'b0, got); check("R6 stamp kept", got, exp_stamp[0]);
    drive(0, 1'b0, v);
    settle();
    ctrl_word[2] = 1'b1;
    settle();

    // R10: both channels on the same edge
    @(negedge clk);
    #1;
    v = time_ns + 64'd2;
    trig_in = 2'b11;
    repeat (3) @(negedge clk);
    check("R10 both events", 64'(evt_vec), 64'h0300_0000);
    exp_stamp[0] = v;
    exp_stamp[1] = v;
    rd_stamp(1'b0, got); check("R10 ch0", got, v);
    rd_stamp(1'b1, got); check("R10 ch1", got, v);
    trig_in = 2'b00;
    settle();

    // R7: second capture overwrites an unread one
    drive(0, 1'b1, v);
    settle();
    drive(0, 1'b0, v2);
    settle();
    drive(0, 1'b1, v2);
    settle();
    exp_stamp[0] = v2;
    rd_stamp(1'b0, got); check("R7 newest", got, v2);
    drive(0, 1'b0, v);
    settle();

    // R9: high read snapshots low half across a new capture
    rd_word(2'b10, w); check("R9 hi", 64'(w), 64'(exp_stamp[1][63:32]));
    drive(1, 1'b1, v);
    settle();
    rd_word(2'b11, w); check("R9 old lo", 64'(w), 64'(exp_stamp[1][31:0]));
    exp_stamp[1] = v;
    rd_stamp(1'b1, got); check("R9 new pair", got, v);
    drive(1, 1'b0, v);
    settle();

    // Capture and high-word read of channel 0 on the same edge
    drive(0, 1'b1, v);
    @(negedge clk);
    @(negedge clk);
    rd_en   = 1'b1;
    rd_addr = 2'b00;
    @(negedge clk);
    w     = rd_data;
    rd_en = 1'b0;
    check("R5 same-cycle event", 64'(evt_vec), 64'h0100_0000);
    check("R9 same-cycle hi old", 64'(w), 64'(exp_stamp[0][63:32]));
    rd_word(2'b01, w); check("R9 same-cycle lo old", 64'(w), 64'(exp_stamp[0][31:0]));
    exp_stamp[0] = v;
    rd_stamp(1'b0, got); check("R4 same-cycle new", got, v);

    $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end
endmodule